// File: doc/BRIEF.md
# Vector Lane Logical Unit

This block is the logical execution unit of a small SIMD coprocessor. It holds a file of vector registers. Each register is split into 16-bit lanes. The block also holds a lane accumulator made of three slices: low, mid and high. An issued instruction names two source registers, a destination register, an element selector and an opcode. The unit first reorders the lanes of the second source as the element selector directs. It then combines that reordered copy with the first source lane by lane, using one of six bitwise operations. On the next clock edge the result goes both to the destination register and to the low accumulator slice.

A separate load port fills registers and a separate accumulator port fills any accumulator slice. A combinational read port shows the contents of any register. Opcodes outside the defined set are accepted but do nothing.

Top module: `vlu_top`

## Requirements
- R1: After a clock edge with `rst_n` low, every register reads zero, all three accumulator slices are zero and `wb_valid` is low.
- R2: A load on `ld_valid` writes `ld_data` to register `ld_idx`, and `rd_data` shows it from the next cycle on. A load on `acc_ld_valid` writes `acc_ld_data` to the slice chosen by `acc_ld_slice`: 0 is low, 1 is mid and 2 is high.
- R3: The opcode encoding is 0 AND, 1 OR, 2 XOR, 4 NAND, 5 NOR and 6 XNOR. Each operation is applied bitwise in every lane. Opcodes 4 to 6 are the bitwise inverse of opcodes 0 to 2.
- R4: Output lane i takes its second operand from lane s of register `op_src_b`. For e equal to 0 or 1, s = i. For e equal to 2 or 3, s = (i with bit 0 cleared) + e - 2. For e from 4 to 7, s = (i with bits 1:0 cleared) + e - 4. For e from 8 to 15, s = e - 8. The first operand is always the unshuffled register `op_src_a`.
- R5: A defined instruction sampled at a clock edge writes `op_dst` at that same edge. In the following cycle `wb_valid` is high and `wb_data` holds the result.
- R6: Every defined instruction also writes its result to the low accumulator slice. The mid and high slices do not change.
- R7: Opcodes 3, 7 and 8 to 15 change no register and no accumulator slice, and they leave `wb_valid` low.
- R8: An instruction issued in the cycle right after another one reads the value that the earlier instruction wrote.
- R9: If an instruction and a register load target the same register in the same cycle, the instruction result is stored. If an instruction coincides with an accumulator load of the low slice, the instruction result is stored there too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction issue strobe |
| op_code | input | 4 | Operation code |
| op_src_a | input | 5 | First source register index |
| op_src_b | input | 5 | Second (shuffled) source register index |
| op_dst | input | 5 | Destination register index |
| op_elem | input | 4 | Element selector for the shuffle |
| ld_valid | input | 1 | Register load strobe |
| ld_idx | input | 5 | Register load index |
| ld_data | input | 128 | Register load data |
| acc_ld_valid | input | 1 | Accumulator slice load strobe |
| acc_ld_slice | input | 2 | Slice to load (0 low, 1 mid, 2 high) |
| acc_ld_data | input | 128 | Accumulator load data |
| rd_idx | input | 5 | Read port register index |
| rd_data | output | 128 | Read port data (combinational) |
| wb_valid | output | 1 | Result strobe, one cycle after issue |
| wb_data | output | 128 | Result of the last instruction |
| acc_lo | output | 128 | Low accumulator slice |
| acc_mid | output | 128 | Mid accumulator slice |
| acc_hi | output | 128 | High accumulator slice |

## Verification
The bench builds the unit with its default parameters: 32 registers of eight 16-bit lanes, with a 4-bit element selector. This size exposes every shuffle group, from the identity through pairs and quads to a full broadcast of each of the eight lanes. It also lets the highest register index be checked at reset. Every lane of the test vectors holds a different value, so a wrong lane choice always shows up in the result.

// File: rtl/vlu_pkg.sv
// Package: shared opcode fields and helpers for the vector logical unit.
// Assumes a 4-bit opcode: bit 3 must be clear, bits 1:0 pick the base
// operation and bit 2 inverts its result.
package vlu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [1:0] {
        BASE_AND = 2'd0,
        BASE_OR  = 2'd1,
        BASE_XOR = 2'd2,
        BASE_BAD = 2'd3
    } base_op_e;

    // True when the opcode selects one of the six logical operations.
    function automatic logic opc_defined(input logic [OPC_W-1:0] opc);
        return (opc[3] == 1'b0) && (opc[1:0] != BASE_BAD);
    endfunction

endpackage

// File: rtl/vlu_shuffle.sv
// Module: lane shuffle of the second operand.
// For each output lane it picks a source lane from the element selector.
// A selector below 2 passes the lanes through unchanged. A selector in
// [2^k, 2^(k+1)) broadcasts lane (e - 2^k) inside each aligned group of
// 2^k lanes. Assumes LANES is a power of two.
module vlu_shuffle #(
    parameter int LANES  = 8,
    parameter int LANE_W = 16,
    parameter int ELEM_W = $clog2(LANES) + 1,
    parameter int VEC_W  = LANES * LANE_W
) (
    input  logic [VEC_W-1:0]  vec_in,
    input  logic [ELEM_W-1:0] elem,
    output logic [VEC_W-1:0]  vec_out
);

    localparam int LIDX_W = $clog2(LANES);

    // Returns the source lane for output lane 'lane' under selector 'e'.
    function automatic logic [LIDX_W-1:0] src_lane(input int lane, input int e);
        int grp;
        grp = 1;
        if (e < 2) return LIDX_W'(lane);
        for (int j = 1; j < ELEM_W; j++) begin
            if (e >= (1 << j)) grp = 1 << j;
        end
        return LIDX_W'((lane & ~(grp - 1)) | (e - grp));
    endfunction

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LIDX_W-1:0] sel;
        // Pick this lane's source and route it out.
        always_comb begin
            sel = src_lane(g, int'(elem));
            vec_out[g*LANE_W +: LANE_W] = vec_in[int'(sel)*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/vlu_logic.sv
// Module: per-lane bitwise logic.
// Applies AND, OR or XOR lane by lane and inverts the result when the
// opcode's invert bit is set. The output is not meaningful for an
// undefined opcode; the caller gates the write-back.
module vlu_logic
    import vlu_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 16,
    parameter int VEC_W  = LANES * LANE_W
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] y
);

    base_op_e base;
    logic     invert;

    // Split the opcode into its base operation and invert bit.
    always_comb begin
        base   = base_op_e'(opc[1:0]);
        invert = opc[2];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] la, lb, raw;
        // Compute the base operation for one lane, then optionally invert it.
        always_comb begin
            la = a[g*LANE_W +: LANE_W];
            lb = b[g*LANE_W +: LANE_W];
            case (base)
                BASE_AND: raw = la & lb;
                BASE_OR:  raw = la | lb;
                BASE_XOR: raw = la ^ lb;
                default:  raw = '0;
            endcase
            y[g*LANE_W +: LANE_W] = invert ? ~raw : raw;
        end
    end

endmodule

// File: rtl/vlu_regfile.sv
// Module: vector register file.
// It has two combinational operand read ports and one inspection read
// port. It has two write ports: a load port and the result port. When both
// write the same entry, the result port wins. The whole file clears on
// the synchronous active-low reset.
module vlu_regfile #(
    parameter int NUM_REGS = 32,
    parameter int VEC_W    = 128,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output logic [VEC_W-1:0] ra_data,
    input  logic [IDX_W-1:0] rb_idx,
    output logic [VEC_W-1:0] rb_data,
    input  logic [IDX_W-1:0] rc_idx,
    output logic [VEC_W-1:0] rc_data,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [VEC_W-1:0] ld_data,
    input  logic             res_we,
    input  logic [IDX_W-1:0] res_idx,
    input  logic [VEC_W-1:0] res_data
);

    logic [VEC_W-1:0] mem [NUM_REGS];

    // Serve the three read ports straight from storage.
    always_comb begin
        ra_data = mem[ra_idx];
        rb_data = mem[rb_idx];
        rc_data = mem[rc_idx];
    end

    // Clear on reset; otherwise apply the load, then the result (priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else begin
            if (ld_we)  mem[ld_idx]  <= ld_data;
            if (res_we) mem[res_idx] <= res_data;
        end
    end

endmodule

// File: rtl/vlu_accum.sv
// Module: three-slice lane accumulator (0 low, 1 mid, 2 high).
// Any slice can be loaded from outside. The result port writes only the
// low slice and takes priority over an outside load of that slice.
module vlu_accum #(
    parameter int VEC_W  = 128,
    parameter int SLICES = 3,
    parameter int SEL_W  = $clog2(SLICES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_we,
    input  logic [SEL_W-1:0] ext_sel,
    input  logic [VEC_W-1:0] ext_data,
    input  logic             res_we,
    input  logic [VEC_W-1:0] res_data,
    output logic [VEC_W-1:0] slice_q [SLICES]
);

    // Clear on reset; outside load first, result write to low slice last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLICES; i++) slice_q[i] <= '0;
        end else begin
            if (ext_we && (int'(ext_sel) < SLICES)) slice_q[ext_sel] <= ext_data;
            if (res_we) slice_q[0] <= res_data;
        end
    end

    // R6: the mid slice holds unless it is loaded from outside.
    a_r6_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_we && ext_sel == SEL_W'(1)) |=> $stable(slice_q[1]));

    // R6: the high slice holds unless it is loaded from outside.
    a_r6_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_we && ext_sel == SEL_W'(2)) |=> $stable(slice_q[2]));

endmodule

// File: rtl/vlu_top.sv
// Module: vector lane logical unit (top).
// Reads the operands when an instruction issues, shuffles the second
// operand and applies the logical operation. At the same clock edge it
// writes the result to the destination register and the low accumulator
// slice. It registers a result strobe and the result data for one cycle.
// An undefined opcode is a no-op.
module vlu_top
    import vlu_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int LANES    = 8,
    parameter int LANE_W   = 16,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter int ELEM_W   = $clog2(LANES) + 1,
    parameter int VEC_W    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [IDX_W-1:0]  op_src_a,
    input  logic [IDX_W-1:0]  op_src_b,
    input  logic [IDX_W-1:0]  op_dst,
    input  logic [ELEM_W-1:0] op_elem,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [VEC_W-1:0]  ld_data,
    input  logic              acc_ld_valid,
    input  logic [1:0]        acc_ld_slice,
    input  logic [VEC_W-1:0]  acc_ld_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [VEC_W-1:0]  rd_data,
    output logic              wb_valid,
    output logic [VEC_W-1:0]  wb_data,
    output logic [VEC_W-1:0]  acc_lo,
    output logic [VEC_W-1:0]  acc_mid,
    output logic [VEC_W-1:0]  acc_hi
);

    localparam int SLICES = 3;

    logic [VEC_W-1:0] opnd_a, opnd_b_raw, opnd_b_shuf, result;
    logic             do_write;
    logic [VEC_W-1:0] acc_q [SLICES];

    // Qualify the write-back: issued and opcode defined.
    always_comb do_write = op_valid && opc_defined(op_code);

    vlu_regfile #(.NUM_REGS(NUM_REGS), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (op_src_a),
        .ra_data  (opnd_a),
        .rb_idx   (op_src_b),
        .rb_data  (opnd_b_raw),
        .rc_idx   (rd_idx),
        .rc_data  (rd_data),
        .ld_we    (ld_valid),
        .ld_idx   (ld_idx),
        .ld_data  (ld_data),
        .res_we   (do_write),
        .res_idx  (op_dst),
        .res_data (result)
    );

    vlu_shuffle #(.LANES(LANES), .LANE_W(LANE_W), .ELEM_W(ELEM_W), .VEC_W(VEC_W)) u_shuf (
        .vec_in  (opnd_b_raw),
        .elem    (op_elem),
        .vec_out (opnd_b_shuf)
    );

    vlu_logic #(.LANES(LANES), .LANE_W(LANE_W), .VEC_W(VEC_W)) u_logic (
        .opc (op_code),
        .a   (opnd_a),
        .b   (opnd_b_shuf),
        .y   (result)
    );

    vlu_accum #(.VEC_W(VEC_W), .SLICES(SLICES), .SEL_W(2)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_we   (acc_ld_valid),
        .ext_sel  (acc_ld_slice),
        .ext_data (acc_ld_data),
        .res_we   (do_write),
        .res_data (result),
        .slice_q  (acc_q)
    );

    // Expose the accumulator slices.
    always_comb begin
        acc_lo  = acc_q[0];
        acc_mid = acc_q[1];
        acc_hi  = acc_q[2];
    end

    // Register the result strobe and data for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= do_write;
            if (do_write) wb_data <= result;
        end
    end

    // R5: a defined instruction raises the result strobe one cycle later.
    a_r5_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_code[3] && op_code[1:0] != 2'b11) |=> wb_valid);

    // R7: an undefined opcode leaves the strobe low.
    a_r7_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code[3] || op_code[1:0] == 2'b11)) |=> !wb_valid);

    // R7: an undefined opcode with no load alongside keeps the low slice.
    a_r7_acc_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code[3] || op_code[1:0] == 2'b11) && !acc_ld_valid)
        |=> $stable(acc_lo));

    // R6: the low slice mirrors each result as it is presented.
    a_r6_acc_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (acc_lo == wb_data));

    // R4: selectors 0 and 1 leave the second operand unshuffled.
    a_r4_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_elem < ELEM_W'(2)) |-> (opnd_b_shuf == opnd_b_raw));

endmodule

// File: tb/test_vlu_top.sv
// Directed bench for vlu_top: one task per scenario, each checking itself.
module test_vlu_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [4:0]   op_src_a = '0, op_src_b = '0, op_dst = '0;
    logic [3:0]   op_elem = '0;
    logic         ld_valid = 1'b0;
    logic [4:0]   ld_idx = '0;
    logic [127:0] ld_data = '0;
    logic         acc_ld_valid = 1'b0;
    logic [1:0]   acc_ld_slice = '0;
    logic [127:0] acc_ld_data = '0;
    logic [4:0]   rd_idx = '0;
    logic [127:0] rd_data, wb_data, acc_lo, acc_mid, acc_hi;
    logic         wb_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    vlu_top i_vlu_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
        .op_elem(op_elem), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .acc_ld_valid(acc_ld_valid),
        .acc_ld_slice(acc_ld_slice), .acc_ld_data(acc_ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .wb_valid(wb_valid),
        .wb_data(wb_data), .acc_lo(acc_lo), .acc_mid(acc_mid), .acc_hi(acc_hi)
    );

    // Test vector with a distinct value in each lane.
    function automatic logic [127:0] mk(input logic [15:0] seed);
        logic [127:0] v;
        for (int i = 0; i < 8; i++) v[i*16 +: 16] = seed ^ (16'h1111 * 16'(i)) ^ 16'(i << 12);
        return v;
    endfunction

    // Lane shuffle as stated in R4.
    function automatic logic [127:0] shuf(input logic [127:0] v, input int e);
        logic [127:0] o;
        int s;
        for (int i = 0; i < 8; i++) begin
            if (e < 2)      s = i;
            else if (e < 4) s = (i & ~1) + e - 2;
            else if (e < 8) s = (i & ~3) + e - 4;
            else            s = e - 8;
            o[i*16 +: 16] = v[s*16 +: 16];
        end
        return o;
    endfunction

    // Operation as stated in R3.
    function automatic logic [127:0] ref_op(input logic [3:0] c, input logic [127:0] a, b);
        logic [127:0] r;
        case (c[1:0])
            2'd0:    r = a & b;
            2'd1:    r = a | b;
            default: r = a ^ b;
        endcase
        return c[2] ? ~r : r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] idx, output logic [127:0] v);
        rd_idx = idx;
        #1 v = rd_data;
    endtask

    task automatic load_reg(input logic [4:0] idx, input logic [127:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_idx = idx; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic load_acc(input logic [1:0] sl, input logic [127:0] d);
        @(negedge clk);
        acc_ld_valid = 1'b1; acc_ld_slice = sl; acc_ld_data = d;
        @(negedge clk);
        acc_ld_valid = 1'b0;
    endtask

    task automatic issue(input logic [3:0] c, input logic [4:0] a, b, d, input logic [3:0] e);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_src_a = a; op_src_b = b; op_dst = d; op_elem = e;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    localparam logic [127:0] V1 = mk(16'hA5C3);
    localparam logic [127:0] V2 = mk(16'h3F0E);
    localparam logic [127:0] ONES = '1;

    task automatic t_reset();
        logic [127:0] v;
        read_reg(5'd0, v);  chk("R1 reg0", v, '0);
        read_reg(5'd31, v); chk("R1 reg31", v, '0);
        chk("R1 acc_lo", acc_lo, '0);
        chk("R1 acc_mid", acc_mid, '0);
        chk("R1 acc_hi", acc_hi, '0);
        chk("R1 wb_valid", 128'(wb_valid), '0);
    endtask

    task automatic t_load();
        logic [127:0] v;
        load_reg(5'd1, V1);
        load_reg(5'd2, V2);
        load_reg(5'd3, ONES);
        read_reg(5'd1, v); chk("R2 reg1", v, V1);
        read_reg(5'd2, v); chk("R2 reg2", v, V2);
        load_acc(2'd1, mk(16'h1357));
        load_acc(2'd2, mk(16'h2468));
        chk("R2 acc_mid load", acc_mid, mk(16'h1357));
        chk("R2 acc_hi load", acc_hi, mk(16'h2468));
    endtask

    task automatic t_ops();
        logic [3:0] codes [6] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6};
        logic [127:0] v, exp;
        for (int k = 0; k < 6; k++) begin
            exp = ref_op(codes[k], V1, V2);
            issue(codes[k], 5'd1, 5'd2, 5'(10 + k), 4'd0);
            chk("R5 wb_valid", 128'(wb_valid), 128'd1);
            chk("R3 wb_data", wb_data, exp);
            chk("R6 acc_lo", acc_lo, exp);
            chk("R6 acc_mid kept", acc_mid, mk(16'h1357));
            chk("R6 acc_hi kept", acc_hi, mk(16'h2468));
            read_reg(5'(10 + k), v);
            chk("R5 dst reg", v, exp);
        end
    endtask

    task automatic t_shuffle();
        for (int e = 1; e < 16; e++) begin
            issue(4'd0, 5'd3, 5'd1, 5'd16, 4'(e));
            chk("R4 shuffle", wb_data, shuf(V1, e));
        end
        issue(4'd2, 5'd2, 5'd1, 5'd17, 4'd5);
        chk("R4 shuffle xor", wb_data, V2 ^ shuf(V1, 5));
    endtask

    task automatic t_undef();
        logic [3:0] bad [4] = '{4'd3, 4'd7, 4'd8, 4'd15};
        logic [127:0] v, lo0;
        lo0 = acc_lo;
        for (int k = 0; k < 4; k++) begin
            issue(bad[k], 5'd1, 5'd2, 5'd1, 4'd0);
            chk("R7 no strobe", 128'(wb_valid), '0);
            read_reg(5'd1, v);
            chk("R7 reg kept", v, V1);
            chk("R7 acc_lo kept", acc_lo, lo0);
            chk("R7 acc_mid kept", acc_mid, mk(16'h1357));
        end
    endtask

    task automatic t_back2back();
        logic [127:0] v;
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd2; op_src_a = 5'd1; op_src_b = 5'd2; op_dst = 5'd20; op_elem = 4'd0;
        @(negedge clk);
        op_src_a = 5'd20; op_src_b = 5'd1; op_dst = 5'd21;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8 chained wb", wb_data, V2);
        read_reg(5'd21, v);
        chk("R8 chained reg", v, V2);
    endtask

    task automatic t_collide();
        logic [127:0] v, exp;
        exp = V1 | V2;
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd1; op_src_a = 5'd1; op_src_b = 5'd2; op_dst = 5'd5; op_elem = 4'd0;
        ld_valid = 1'b1; ld_idx = 5'd5; ld_data = mk(16'hDEAD);
        acc_ld_valid = 1'b1; acc_ld_slice = 2'd0; acc_ld_data = mk(16'hBEEF);
        @(negedge clk);
        op_valid = 1'b0; ld_valid = 1'b0; acc_ld_valid = 1'b0;
        read_reg(5'd5, v);
        chk("R9 reg priority", v, exp);
        chk("R9 acc priority", acc_lo, exp);
        load_acc(2'd0, mk(16'hBEEF));
        chk("R2 acc_lo load", acc_lo, mk(16'hBEEF));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load();
        t_ops();
        t_shuffle();
        t_undef();
        t_back2back();
        t_collide();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule